// File: doc/BRIEF.md
# Dual-Bank Configuration Image Validator

This block decides which of two stored configuration images is current. Each image is a fixed-size block of bytes (8 KB by default) behind a byte-wide read port. An image carries a short header: a marker byte, an 8-bit header checksum, a 32-bit body checksum and a 32-bit generation counter. After a start pulse the block reads every byte of bank 0 and then every byte of bank 1, in ascending order. It checks the marker and both checksums for each bank. It then reports which banks hold a valid image, which bank is active, and the generation of the active bank.

The header checksum is a byte sum with end-around carry. The body checksum is a dual running sum modulo 65521 that starts a few bytes into the image. A bank that fails any check reports a generation of zero. The newer bank wins. On a tie, bank 0 wins. Firmware or a boot sequencer pulses start once and waits for the done pulse before it uses the result.

Top module: `nvhdr_bank_select`

## Requirements
- R1: An image is valid only if its byte at offset 0 equals 0x5A.
- R2: The header checksum is the 16-bit sum of byte 0 and bytes 2 to 15. The sum is folded by adding its upper byte to its lower byte until it fits in 8 bits. The image is valid only if the result equals byte 1.
- R3: The body checksum runs over bytes 0x14 to the last byte of the image. It keeps a low sum that starts at 1 and a high sum that starts at 0. For each byte, the byte is added to the low sum and then the new low sum is added to the high sum, both modulo 65521. The value is high*65536+low. The image is valid only if this value equals the 32-bit big-endian word at offset 16 (offset 16 is the most significant byte).
- R4: Both running sums stay below 65521 on every clock cycle.
- R5: The generation is the 32-bit big-endian word at offset 20. A bank's reported generation is this word if the bank is valid and zero otherwise. bank_valid_o bit b is 1 exactly when bank b is valid.
- R6: Bank 1 is active only if its reported generation is strictly greater than bank 0's. Otherwise bank 0 is active. active_gen_o is the reported generation of the active bank.
- R7: done_o is a one-cycle pulse. It rises after the (2N+4)-th rising clock edge, counting the edge that samples start_i as edge 0, where N is the image size. The result outputs stay steady until the next run completes.
- R8: The block reads one byte per cycle. It reads bank 0 offsets 0 to N-1 and then bank 1 offsets 0 to N-1. The bank is given by the top address bit (bit 13 at the default size). The byte read is expected on mem_rdata_i in the next cycle.
- R9: A start_i pulse while busy_o is high is ignored. It changes neither the read sequence nor the done timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse; sampled only while idle |
| mem_rd_o | output | 1 | Read strobe to the image memory |
| mem_addr_o | output | 14 | Read address: top bit is the bank, lower bits the byte offset |
| mem_rdata_i | input | 8 | Byte read, valid one cycle after the strobe |
| busy_o | output | 1 | High while a two-bank scan is in progress |
| done_o | output | 1 | One-cycle pulse when the result outputs are updated |
| bank_valid_o | output | 2 | Per-bank validity of the last scan |
| active_bank_o | output | 1 | Bank selected by the last scan |
| active_gen_o | output | 32 | Reported generation of the selected bank |

## Verification
The assertions assume three things. The memory answers every strobe with the byte at that address exactly one cycle later. The image contents do not change during a scan. start_i is a pulse. The bench memory model registers the byte for each strobe at the next edge. It builds both images before a run starts and leaves them untouched until done_o. It drives start_i for a single cycle, apart from a deliberate second pulse sent while busy to check that a start during a scan is ignored.

// File: rtl/nvhdr_pkg.sv
package nvhdr_pkg;
  localparam logic [7:0]  SIG_BYTE  = 8'h5A;
  localparam int unsigned ADL_MOD   = 65521;
  localparam int unsigned CK_OFS    = 1;
  localparam int unsigned HSUM_LAST = 15;
  localparam int unsigned ADL_OFS   = 16;
  localparam int unsigned GEN_OFS   = 20;
  localparam int unsigned BODY_OFS  = 20;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BANK0 = 2'd1,
    ST_BANK1 = 2'd2
  } seq_state_e;
endpackage

// File: rtl/nvhdr_hdr_sum.sv
module nvhdr_hdr_sum (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic [7:0] byte_i,
  output logic [7:0] fold_o
);
  logic [15:0] acc_q, acc_d;
  logic [15:0] f;

  always_comb begin
    acc_d = acc_q;
    if (clr_i)     acc_d = '0;
    else if (en_i) acc_d = acc_q + {8'h00, byte_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // end-around carry fold, enough passes for any 16-bit sum
  always_comb begin
    f = acc_q;
    for (int k = 0; k < 3; k++) begin
      if (f > 16'h00FF) f = {8'h00, f[7:0]} + {8'h00, f[15:8]};
    end
    fold_o = f[7:0];
  end
endmodule

// File: rtl/nvhdr_body_sum.sv
module nvhdr_body_sum (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] sum_o
);
  import nvhdr_pkg::*;
  localparam logic [16:0] MOD17 = 17'(ADL_MOD);

  logic [15:0] low_q, high_q, low_d, high_d;
  logic [16:0] lo_sum, hi_sum;
  logic [15:0] lo_n, hi_n;

  always_comb begin
    lo_sum = {1'b0, low_q} + {9'b0, byte_i};
    lo_n   = (lo_sum >= MOD17) ? 16'(lo_sum - MOD17) : lo_sum[15:0];
    hi_sum = {1'b0, high_q} + {1'b0, lo_n};
    hi_n   = (hi_sum >= MOD17) ? 16'(hi_sum - MOD17) : hi_sum[15:0];
    low_d  = low_q;
    high_d = high_q;
    if (clr_i) begin
      low_d  = 16'd1;
      high_d = 16'd0;
    end else if (en_i) begin
      low_d  = lo_n;
      high_d = hi_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= 16'd1;
      high_q <= 16'd0;
    end else begin
      low_q  <= low_d;
      high_q <= high_d;
    end
  end

  assign sum_o = {high_q, low_q};

  // R4: running sums always reduced
  p_sums_below_mod_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (low_q < MOD17[15:0]) && (high_q < MOD17[15:0]));
endmodule

// File: rtl/nvhdr_scan.sv
module nvhdr_scan #(
  parameter int unsigned IMG_BYTES = 8192,
  localparam int unsigned IDX_W    = $clog2(IMG_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             rd_o,
  output logic [IDX_W-1:0] addr_o,
  input  logic [7:0]       rdata_i,
  output logic             done_o,
  output logic             ok_o,
  output logic [31:0]      gen_o
);
  import nvhdr_pkg::*;
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(IMG_BYTES - 1);
  localparam logic [IDX_W-1:0] I_CK  = IDX_W'(CK_OFS);
  localparam logic [IDX_W-1:0] I_HL  = IDX_W'(HSUM_LAST);
  localparam logic [IDX_W-1:0] I_ADL = IDX_W'(ADL_OFS);
  localparam logic [IDX_W-1:0] I_GEN = IDX_W'(GEN_OFS);
  localparam logic [IDX_W-1:0] I_BDY = IDX_W'(BODY_OFS);

  logic             issue_q, issue_d, rvld_q, done_q;
  logic [IDX_W-1:0] cnt_q, cnt_d, ridx_q;
  logic [7:0]       sig_q, sig_d, ck_q, ck_d;
  logic [31:0]      adl_q, adl_d, gen_q, gen_d;
  logic             accept, hdr_en, body_en;
  logic [7:0]       hdr_fold;
  logic [31:0]      body_sum;

  assign accept = start_i && !issue_q && !rvld_q;

  always_comb begin
    issue_d = issue_q;
    cnt_d   = cnt_q;
    if (accept) begin
      issue_d = 1'b1;
      cnt_d   = '0;
    end else if (issue_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) issue_d = 1'b0;
    end
    sig_d = sig_q;
    ck_d  = ck_q;
    adl_d = adl_q;
    gen_d = gen_q;
    if (rvld_q) begin
      if (ridx_q == '0)   sig_d = rdata_i;
      if (ridx_q == I_CK) ck_d  = rdata_i;
      if (ridx_q >= I_ADL && ridx_q < I_GEN) adl_d = {adl_q[23:0], rdata_i};
      if (ridx_q >= I_GEN && ridx_q < I_GEN + 4) gen_d = {gen_q[23:0], rdata_i};
    end
  end

  assign hdr_en  = rvld_q && (ridx_q == '0 || (ridx_q > I_CK && ridx_q <= I_HL));
  assign body_en = rvld_q && (ridx_q >= I_BDY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue_q <= 1'b0;
      cnt_q   <= '0;
      rvld_q  <= 1'b0;
      ridx_q  <= '0;
      done_q  <= 1'b0;
      sig_q   <= '0;
      ck_q    <= '0;
      adl_q   <= '0;
      gen_q   <= '0;
    end else begin
      issue_q <= issue_d;
      cnt_q   <= cnt_d;
      rvld_q  <= issue_q;
      ridx_q  <= cnt_q;
      done_q  <= rvld_q && (ridx_q == LAST);
      sig_q   <= sig_d;
      ck_q    <= ck_d;
      adl_q   <= adl_d;
      gen_q   <= gen_d;
    end
  end

  nvhdr_hdr_sum u_hdr (
    .clk(clk), .rst_n(rst_n), .clr_i(accept), .en_i(hdr_en),
    .byte_i(rdata_i), .fold_o(hdr_fold)
  );

  nvhdr_body_sum u_body (
    .clk(clk), .rst_n(rst_n), .clr_i(accept), .en_i(body_en),
    .byte_i(rdata_i), .sum_o(body_sum)
  );

  assign rd_o   = issue_q;
  assign addr_o = cnt_q;
  assign done_o = done_q;
  assign ok_o   = (sig_q == SIG_BYTE) && (hdr_fold == ck_q) && (body_sum == adl_q);
  assign gen_o  = ok_o ? gen_q : 32'd0;

  // R8: consecutive reads step the offset by one
  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_o && $past(rd_o) |-> addr_o == $past(addr_o) + 1'b1);
  // R8: every strobe is followed by a data slot
  p_data_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_o |=> rvld_q);
endmodule

// File: rtl/nvhdr_bank_select.sv
module nvhdr_bank_select #(
  parameter int unsigned IMG_BYTES = 8192,
  localparam int unsigned IDX_W    = $clog2(IMG_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             mem_rd_o,
  output logic [IDX_W:0]   mem_addr_o,
  input  logic [7:0]       mem_rdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       bank_valid_o,
  output logic             active_bank_o,
  output logic [31:0]      active_gen_o
);
  import nvhdr_pkg::*;

  logic [1:0]       rs_q;
  logic             rst_ns;
  seq_state_e       st_q, st_d;
  logic             sc_start, sc_rd, sc_done, sc_ok;
  logic [IDX_W-1:0] sc_addr;
  logic [31:0]      sc_gen;
  logic             v0_q, v0_d;
  logic [31:0]      g0_q, g0_d;
  logic             done_q, done_d, abank_q, abank_d;
  logic [1:0]       bval_q, bval_d;
  logic [31:0]      agen_q, agen_d;
  logic             pick1;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  assign sc_start = (st_q == ST_IDLE && start_i) || (st_q == ST_BANK0 && sc_done);
  assign pick1    = sc_gen > g0_q;

  always_comb begin
    st_d    = st_q;
    v0_d    = v0_q;
    g0_d    = g0_q;
    done_d  = 1'b0;
    bval_d  = bval_q;
    abank_d = abank_q;
    agen_d  = agen_q;
    case (st_q)
      ST_IDLE:  if (start_i) st_d = ST_BANK0;
      ST_BANK0: if (sc_done) begin
        st_d = ST_BANK1;
        v0_d = sc_ok;
        g0_d = sc_gen;
      end
      ST_BANK1: if (sc_done) begin
        st_d    = ST_IDLE;
        done_d  = 1'b1;
        bval_d  = {sc_ok, v0_q};
        abank_d = pick1;
        agen_d  = pick1 ? sc_gen : g0_q;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q    <= ST_IDLE;
      v0_q    <= 1'b0;
      g0_q    <= '0;
      done_q  <= 1'b0;
      bval_q  <= '0;
      abank_q <= 1'b0;
      agen_q  <= '0;
    end else begin
      st_q    <= st_d;
      v0_q    <= v0_d;
      g0_q    <= g0_d;
      done_q  <= done_d;
      bval_q  <= bval_d;
      abank_q <= abank_d;
      agen_q  <= agen_d;
    end
  end

  nvhdr_scan #(.IMG_BYTES(IMG_BYTES)) u_scan (
    .clk(clk), .rst_n(rst_ns), .start_i(sc_start),
    .rd_o(sc_rd), .addr_o(sc_addr), .rdata_i(mem_rdata_i),
    .done_o(sc_done), .ok_o(sc_ok), .gen_o(sc_gen)
  );

  assign mem_rd_o      = sc_rd;
  assign mem_addr_o    = {st_q == ST_BANK1, sc_addr};
  assign busy_o        = st_q != ST_IDLE;
  assign done_o        = done_q;
  assign bank_valid_o  = bval_q;
  assign active_bank_o = abank_q;
  assign active_gen_o  = agen_q;

  // R7: done lasts a single cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    done_o |=> !done_o);
  // R6: bank 1 only chosen when it is valid
  p_pick_valid_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    done_o && active_bank_o |-> bank_valid_o[1]);
  // R5: no valid bank means a zero generation
  p_none_zero_gen_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    done_o && (bank_valid_o == 2'b00) |-> active_gen_o == 32'd0);
  // R8: reads only while a scan is running
  p_rd_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    mem_rd_o |-> busy_o);
endmodule

// File: tb/nvhdr_bank_select_tb_top.sv
module nvhdr_bank_select_tb_top;
  localparam int N  = 8192;
  localparam int AW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          mem_rd_o;
  logic [AW:0]   mem_addr_o;
  logic [7:0]    mem_rdata_i = 8'h00;
  logic          busy_o, done_o, active_bank_o;
  logic [1:0]    bank_valid_o;
  logic [31:0]   active_gen_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int addr_err = 0;
  logic [7:0] hdr [0:1][0:23];
  int seeds [0:1];
  int exp_q [$];
  logic       pend_rd = 1'b0;
  logic [AW:0] pend_addr = '0;

  always #2.5 clk = ~clk;

  nvhdr_bank_select #(.IMG_BYTES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .bank_valid_o(bank_valid_o),
    .active_bank_o(active_bank_o), .active_gen_o(active_gen_o)
  );

  function automatic logic [7:0] fill_byte(int b, int idx);
    return 8'((idx * seeds[b]) + (idx >> 4) + b * 91);
  endfunction

  function automatic logic [7:0] byte_at(int b, int idx);
    if (idx < 24) return hdr[b][idx];
    return fill_byte(b, idx);
  endfunction

  // memory model: strobe seen away from the edge, byte returned at next edge
  always @(negedge clk) begin
    pend_rd   <= mem_rd_o;
    pend_addr <= mem_addr_o;
    if (mem_rd_o) begin
      if (exp_q.size() == 0) addr_err++;
      else if (exp_q.pop_front() != int'(mem_addr_o)) addr_err++;
    end
  end
  always @(posedge clk) begin
    if (pend_rd) mem_rdata_i <= byte_at(int'(pend_addr[AW]), int'(pend_addr[AW-1:0]));
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected below 200000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // mode: 0 good, 1 bad marker, 2 bad header sum, 3 bad body sum
  task automatic build(int b, logic [31:0] gen, int seed, int mode);
    int lo = 1;
    int hi = 0;
    int hs;
    seeds[b] = seed;
    for (int i = 0; i < 24; i++) hdr[b][i] = 8'(i * 13 + seed + 200);
    hdr[b][20] = gen[31:24]; hdr[b][21] = gen[23:16];
    hdr[b][22] = gen[15:8];  hdr[b][23] = gen[7:0];
    hdr[b][0]  = (mode == 1) ? 8'h5B : 8'h5A;
    for (int i = 20; i < N; i++) begin
      lo = (lo + int'(byte_at(b, i))) % 65521;
      hi = (hi + lo) % 65521;
    end
    hdr[b][16] = 8'(hi >> 8); hdr[b][17] = 8'(hi);
    hdr[b][18] = 8'(lo >> 8); hdr[b][19] = 8'(lo);
    if (mode == 3) hdr[b][19] = hdr[b][19] ^ 8'h01;
    hs = int'(hdr[b][0]);
    for (int i = 2; i < 16; i++) hs += int'(hdr[b][i]);
    while (hs > 255) hs = (hs & 255) + (hs >> 8);
    hdr[b][1] = 8'(hs);
    if (mode == 2) hdr[b][1] = hdr[b][1] ^ 8'h01;
  endtask

  task automatic run(string tag, logic [31:0] g0, int m0, logic [31:0] g1, int m1,
                     bit poke);
    logic [31:0] r0, r1, eg;
    logic        esel;
    int          bad_j = -1;
    logic [1:0]  bv;
    logic        ab;
    logic [31:0] ag;
    build(0, g0, 7, m0);
    build(1, g1, 29, m1);
    r0 = (m0 == 0) ? g0 : 32'd0;
    r1 = (m1 == 0) ? g1 : 32'd0;
    esel = r1 > r0;
    eg = esel ? r1 : r0;
    exp_q.delete();
    addr_err = 0;
    for (int i = 0; i < 2 * N; i++) exp_q.push_back(i);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    for (int j = 1; j <= 2 * N + 4; j++) begin
      @(negedge clk);
      start_i = (poke && j == 100);
      if (done_o !== (j == 2 * N + 4) && bad_j < 0) bad_j = j;
    end
    start_i = 1'b0;
    check({tag, " R7 done timing (first bad cycle in actual)"}, bad_j, -1);
    check({tag, " R5 bank_valid"}, {30'd0, bank_valid_o}, {30'd0, m1 == 0, m0 == 0});
    check({tag, " R6 active_bank"}, {31'd0, active_bank_o}, {31'd0, esel});
    check({tag, " R5 R6 active_gen"}, active_gen_o, eg);
    check({tag, " R8 read order (errors, left)"}, addr_err + exp_q.size(), 0);
    bv = bank_valid_o; ab = active_bank_o; ag = active_gen_o;
    repeat (3) @(negedge clk);
    check({tag, " R7 single pulse"}, {31'd0, done_o}, 32'd0);
    check({tag, " R7 result held"}, {bank_valid_o, active_bank_o, ag == active_gen_o},
          {bv, ab, 1'b1});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("reset done", {31'd0, done_o}, 0);
    check("reset busy/rd", {30'd0, busy_o, mem_rd_o}, 0);
    check("reset results", {29'd0, bank_valid_o, active_bank_o}, 0);
    check("reset gen", active_gen_o, 0);
    run("R3 R4 both good newer b1", 32'd5, 0, 32'd9, 0, 1'b0);
    run("R6 tie picks b0", 32'h0001_0009, 0, 32'h0001_0009, 0, 1'b0);
    run("R6 older b1", 32'h10, 0, 32'h3, 0, 1'b0);
    run("R1 bad marker b1", 32'h4, 0, 32'hFFFF_0000, 1, 1'b0);
    run("R2 bad header sum b0", 32'h8000_0000, 2, 32'h2, 0, 1'b0);
    run("R3 bad body sum b1 R9 poke", 32'h7, 0, 32'h7000_0000, 3, 1'b1);
    run("R5 both invalid", 32'h11, 1, 32'h22, 2, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule